// File: doc/BRIEF.md
# Oversampling UART receiver with per-character error status

This block turns an asynchronous serial line into characters. A clock enable pulses at sixteen times the bit rate. The block waits for a falling edge and requires the line to stay low for half a bit time before it accepts a start bit. It then samples each later bit once, at its nominal centre. It accepts 5 to 8 data bits, least-significant bit first, an optional even or odd parity bit, and one stop bit.

Each finished character moves into a holding register, and a ready flag rises. Parity error, framing error and line break are captured with the character and are shown only while the ready flag is set. A read strobe releases the character.

If a character completes while the previous one is still unread, the new character is dropped and an overrun flag is set. The overrun also withdraws the permission-to-send output, so the far end stops transmitting. A separate error-clear pulse removes the overrun and restores that output. Character length and parity mode are static configuration and must not change while a frame is being received.

Top module: `uart_rx_core`

## Requirements
- R1: After reset the ready flag, all error flags and the overrun flag are 0, the data output is 0x00 and `rts_o` is 1.
- R2: A low pulse on the line that ends before eight oversampling ticks have been sampled low is rejected; no character is produced, and a later valid frame is still received correctly.
- R3: Data bits are assembled least-significant first into `data_o`; with `len_sel_i` = 3 (8 bits) and no parity, the transmitted byte appears unchanged.
- R4: `len_sel_i` values 0, 1, 2, 3 select 5, 6, 7, 8 data bits; bits of `data_o` above the selected length read as 0.
- R5: `par_mode_i` = 1 selects even parity, 2 selects odd parity, and 0 or 3 selects no parity bit. When the received parity bit does not match the selected mode, `perr_o` is set for that character.
- R6: A stop bit sampled low sets `ferr_o` for that character.
- R7: When every data bit, the parity bit (if enabled) and the stop bit are all low, `brk_o` is set together with `ferr_o`. A high parity bit prevents `brk_o`.
- R8: A start bit that follows a high stop bit directly, with no idle time, is accepted; both characters are received.
- R9: After a framing error on a non-zero character, if the line is still low half a bit after the stop sample, that point is taken as the edge of a new start bit, and the next character is received.
- R10: A one-cycle `rd_i` pulse clears the ready flag. Per-character error flags read 0 whenever the ready flag is 0.
- R11: A character that completes while the ready flag is set is discarded. `data_o` keeps the unread character, `ovr_o` is set and `rts_o` falls. `rd_i` does not clear these. An `err_clr_i` pulse clears `ovr_o` and raises `rts_o` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| len_sel_i | input | 2 | Data length: 0..3 selects 5..8 bits |
| par_mode_i | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| rd_i | input | 1 | Read strobe, releases the held character |
| err_clr_i | input | 1 | Clears overrun and restores `rts_o` |
| data_o | output | 8 | Held character |
| ready_o | output | 1 | Character available |
| perr_o | output | 1 | Parity error of the held character |
| ferr_o | output | 1 | Framing error of the held character |
| brk_o | output | 1 | Break received as the held character |
| ovr_o | output | 1 | Overrun, sticky until `err_clr_i` |
| rts_o | output | 1 | High while the far end may send |

## Verification
Characters and their flags reach the holding register at the clock edge of the stop-bit sample. That sample falls in the middle of the stop slot, plus at most the two synchronizer flops and one tick period. The bench therefore checks each character only after a further full bit slot of idle line, and it never checks near a slot boundary. Read and error-clear effects are registered, so they are checked on the falling edge that follows the one-cycle strobe. The restart-after-framing-error and back-to-back cases release the first character in the middle of the following slot, well before the second stop sample can cause an overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 8;

  localparam logic [1:0] PM_EVEN = 2'd1;
  localparam logic [1:0] PM_ODD  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_REARM
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] len_sel_i,
  input  logic [1:0] par_mode_i,
  output logic       done_o,
  output rx_char_t   char_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        idx_q;
  logic [CHAR_W-1:0] shreg_q;
  logic              pbit_q;
  logic              armed_q;

  logic       par_en;
  logic [2:0] last_idx;
  logic       bit_mid;

  assign par_en   = (par_mode_i == PM_EVEN) || (par_mode_i == PM_ODD);
  assign last_idx = {1'b1, len_sel_i};  // 5..8 bits -> index 4..7
  assign bit_mid  = tick_i && (cnt_q == BIT_LAST);

  assign done_o      = (state_q == ST_STOP) && bit_mid;
  assign char_o.data = shreg_q;
  assign char_o.ferr = !rx_i;
  assign char_o.brk  = !rx_i && (shreg_q == '0) && (!par_en || !pbit_q);
  assign char_o.perr = par_en && ((^{shreg_q, pbit_q}) != (par_mode_i == PM_ODD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      pbit_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (rx_i)         armed_q <= 1'b1;
          else if (armed_q) state_q <= ST_START;
        end
        ST_START: begin
          if (rx_i) begin
            state_q <= ST_IDLE;  // glitch: search again
            cnt_q   <= '0;
          end else if (cnt_q == HALF_LAST) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            pbit_q  <= 1'b0;
          end
        end
        ST_DATA: begin
          if (cnt_q == BIT_LAST) begin
            cnt_q          <= '0;
            shreg_q[idx_q] <= rx_i;
            idx_q          <= idx_q + 1'b1;
            if (idx_q == last_idx) state_q <= par_en ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (cnt_q == BIT_LAST) begin
            cnt_q   <= '0;
            pbit_q  <= rx_i;
            state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (cnt_q == BIT_LAST) begin
            cnt_q <= '0;
            if (rx_i) begin
              state_q <= ST_IDLE;
              armed_q <= 1'b1;
            end else if (|shreg_q) begin
              state_q <= ST_REARM;
            end else begin
              state_q <= ST_IDLE;  // break: wait for line high
              armed_q <= 1'b0;
            end
          end
        end
        ST_REARM: begin
          if (cnt_q == HALF_LAST) begin
            cnt_q <= '0;
            if (rx_i) begin
              state_q <= ST_IDLE;
              armed_q <= 1'b1;
            end else begin
              state_q <= ST_START;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  rx_char_t          char_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              ready_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o,
  output logic              ovr_o
);
  rx_char_t held_q;
  logic     ready_q;
  logic     ovr_q;
  logic     slot_free;

  assign slot_free = !ready_q || rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (rd_i) begin
        ready_q     <= 1'b0;
        held_q.perr <= 1'b0;
        held_q.ferr <= 1'b0;
        held_q.brk  <= 1'b0;
      end
      if (clr_i) ovr_q <= 1'b0;
      if (load_i) begin
        if (slot_free) begin
          held_q  <= char_i;
          ready_q <= 1'b1;
        end else begin
          ovr_q <= 1'b1;
        end
      end
    end
  end

  assign data_o  = held_q.data;
  assign ready_o = ready_q;
  assign perr_o  = held_q.perr & ready_q;
  assign ferr_o  = held_q.ferr & ready_q;
  assign brk_o   = held_q.brk & ready_q;
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] len_sel_i,
  input  logic [1:0] par_mode_i,
  input  logic       rd_i,
  input  logic       err_clr_i,
  output logic [7:0] data_o,
  output logic       ready_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       brk_o,
  output logic       ovr_o,
  output logic       rts_o
);
  logic     rx_s;
  logic     char_done;
  rx_char_t char_w;

  uart_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rx_i      (rx_s),
    .len_sel_i (len_sel_i),
    .par_mode_i(par_mode_i),
    .done_o    (char_done),
    .char_o    (char_w)
  );

  uart_rx_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (char_done),
    .char_i (char_w),
    .rd_i   (rd_i),
    .clr_i  (err_clr_i),
    .data_o (data_o),
    .ready_o(ready_o),
    .perr_o (perr_o),
    .ferr_o (ferr_o),
    .brk_o  (brk_o),
    .ovr_o  (ovr_o)
  );

  assign rts_o = !ovr_o;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic       err_clr_i,
  input logic [1:0] len_sel_i,
  input logic       char_done_i,
  input logic [7:0] data_o,
  input logic       ready_o,
  input logic       perr_o,
  input logic       ferr_o,
  input logic       brk_o,
  input logic       ovr_o
);
  a_r10_flags_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !(perr_o || ferr_o || brk_o));

  a_r7_break_is_framing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> ferr_o);

  a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && len_sel_i == 2'd0) |-> (data_o[7:5] == 3'b000));

  a_r10_ready_falls_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(rd_i));

  a_r11_overrun_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> ($stable(data_o) && ready_o));

  a_r11_overrun_from_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(char_done_i));

  a_r11_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_o) |-> $past(err_clr_i));

  a_r3_done_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done_i && !ready_o) |=> ready_o);
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .err_clr_i  (err_clr_i),
  .len_sel_i  (len_sel_i),
  .char_done_i(char_done),
  .data_o     (data_o),
  .ready_o    (ready_o),
  .perr_o     (perr_o),
  .ferr_o     (ferr_o),
  .brk_o      (brk_o),
  .ovr_o      (ovr_o)
);

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
  localparam int SLOT = 64;  // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic [1:0] tdiv;
  logic       rxd = 1'b1;
  logic [1:0] len_sel = 2'd3;
  logic [1:0] par_mode = 2'd0;
  logic       rd = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] data;
  logic       ready, perr, ferr, brk, ovr, rts;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdiv <= '0;
    else        tdiv <= tdiv + 1'b1;
  end
  assign tick = (tdiv == 2'd3);

  uart_rx_core u_uart_rx_core (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .rxd_i     (rxd),
    .len_sel_i (len_sel),
    .par_mode_i(par_mode),
    .rd_i      (rd),
    .err_clr_i (err_clr),
    .data_o    (data),
    .ready_o   (ready),
    .perr_o    (perr),
    .ferr_o    (ferr),
    .brk_o     (brk),
    .ovr_o     (ovr),
    .rts_o     (rts)
  );

  // {len, mode, data, flip parity, stop, exp data, exp pe, exp fe, exp brk}
  localparam logic [24:0] VEC [10] = '{
    {2'd3, 2'd0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
    {2'd3, 2'd0, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd0, 8'hFF, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0, 1'b0},
    {2'd1, 2'd1, 8'h2D, 1'b0, 1'b1, 8'h2D, 1'b0, 1'b0, 1'b0},
    {2'd2, 2'd2, 8'h55, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0},
    {2'd2, 2'd2, 8'h55, 1'b1, 1'b1, 8'h55, 1'b1, 1'b0, 1'b0},
    {2'd3, 2'd1, 8'h01, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0},
    {2'd3, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
    {2'd3, 2'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0},
    {2'd1, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    rxd = b;
    repeat (SLOT) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] len, input logic [1:0] pm, input logic [7:0] d,
                      input logic flip, input logic stop);
    logic [7:0] mask;
    mask = 8'hFF >> (3 - len);
    slot(1'b0);
    for (int i = 0; i < int'(len) + 5; i++) slot(d[i]);
    if (pm == 2'd1 || pm == 2'd2) slot((^(d & mask)) ^ (pm == 2'd2) ^ flip);
    slot(stop);
  endtask

  task automatic pulse_rd();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  logic [7:0] first_seen;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", {4'h0, ready, perr, ferr, brk, data}, 16'h0000);
    chk("R1 ovr/rts", {14'h0, ovr, rts}, 16'h0001);
    repeat (SLOT) @(negedge clk);

    // table: R3 R4 R5 R6 R7 R10
    for (int v = 0; v < 10; v++) begin
      len_sel  = VEC[v][24:23];
      par_mode = VEC[v][22:21];
      send(VEC[v][24:23], VEC[v][22:21], VEC[v][20:13], VEC[v][12], VEC[v][11]);
      slot(1'b1);
      chk($sformatf("R3/R4/R5/R6/R7 vector %0d", v),
          {4'h0, ready, perr, ferr, brk, data},
          {4'h0, 1'b1, VEC[v][2:0], VEC[v][10:3]});
      pulse_rd();
      chk($sformatf("R10 vector %0d cleared", v), {12'h0, ready, perr, ferr, brk}, 16'h0000);
    end

    len_sel  = 2'd3;
    par_mode = 2'd0;

    // R2 short low pulses rejected
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (SLOT * 3) @(negedge clk);
    rxd = 1'b0;
    repeat (20) @(negedge clk);
    rxd = 1'b1;
    repeat (SLOT * 12) @(negedge clk);
    chk("R2 glitch ignored", {15'h0, ready}, 16'h0000);
    send(2'd3, 2'd0, 8'h5A, 1'b0, 1'b1);
    slot(1'b1);
    chk("R2 frame after glitch", {7'h0, ready, data}, {7'h0, 1'b1, 8'h5A});
    pulse_rd();

    // R8 back-to-back frames
    first_seen = 8'h00;
    fork
      begin
        send(2'd3, 2'd0, 8'h12, 1'b0, 1'b1);
        send(2'd3, 2'd0, 8'h34, 1'b0, 1'b1);
        slot(1'b1);
      end
      begin
        wait (ready === 1'b1);
        @(negedge clk);
        first_seen = data;
        pulse_rd();
      end
    join
    chk("R8 first char", {8'h0, first_seen}, 16'h0012);
    chk("R8 second char", {7'h0, ready, data}, {7'h0, 1'b1, 8'h34});
    chk("R8 no overrun", {15'h0, ovr}, 16'h0000);
    pulse_rd();

    // R9 restart after framing error on non-zero char
    slot(1'b0);
    for (int i = 0; i < 8; i++) slot(i == 0 || i == 7);  // 0x81
    slot(1'b0);  // low stop
    rxd = 1'b0;  // line stays low
    repeat (SLOT / 2) @(negedge clk);
    chk("R6/R9 first char framing", {4'h0, ready, perr, ferr, brk, data},
        {4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81});
    pulse_rd();
    repeat (SLOT / 2 - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) slot(((8'h3C >> i) & 8'h01) != 8'h00);
    slot(1'b1);
    slot(1'b1);
    chk("R9 char after restart", {4'h0, ready, perr, ferr, brk, data},
        {4'h0, 1'b1, 3'b000, 8'h3C});
    pulse_rd();

    // R11 overrun
    send(2'd3, 2'd0, 8'hC3, 1'b0, 1'b1);
    slot(1'b1);
    send(2'd3, 2'd0, 8'h0F, 1'b0, 1'b1);
    slot(1'b1);
    chk("R11 old data kept", {7'h0, ready, data}, {7'h0, 1'b1, 8'hC3});
    chk("R11 overrun and rts", {14'h0, ovr, rts}, 16'h0002);
    pulse_rd();
    chk("R11 read keeps overrun", {13'h0, ready, ovr, rts}, 16'h0002);
    pulse_clr();
    chk("R11 clear restores rts", {14'h0, ovr, rts}, 16'h0001);
    send(2'd3, 2'd0, 8'h77, 1'b0, 1'b1);
    slot(1'b1);
    chk("R11 receive after clear", {6'h0, ready, ovr, data}, {6'h0, 2'b10, 8'h77});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 8);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule